// File: doc/BRIEF.md
# Per-Port Output Queue Manager with Event Capture

The block is the last stage of a packet datapath. Each packet arrives as a stream of words. The first word is a module header, and that header names the output port and gives the packet length in words. The block steers the packet into one of eight small on-chip queues, one for each output port: four line ports and four host ports. A downstream consumer selects a queue and pops words from it in order. Each queue admits packets only up to a configured number of stored packets. It also admits a packet only if its buffer has room for the whole packet. A packet that fails either test, or that targets a queue switched off by configuration, is discarded whole, and none of its words reaches storage.

Next to the packet path, the block writes a stream of timestamped records into a small record FIFO. A record is written for every packet admitted, every packet discarded and every packet started on the read side. Capture has a global switch and a per-queue monitor mask. When the record FIFO has no room, the record is lost and a sticky flag is raised. The packet path never waits for the record FIFO. The number of complete packets held in each queue is available as a status output.

Top module: `outq_evcap`

## Requirements
- R1: The queue of a packet is taken from bits [2:0] of its first word. All words of an admitted packet are stored in that queue and are read out in the order they were written.
- R2: A first word that arrives when the target queue already holds its limit of complete packets (`q_limit` field i, 5 bits at [5i+4:5i]) causes the whole packet to be discarded. The count never rises above the limit.
- R3: A first word whose length field (bits [15:8]) exceeds the free words left in the target queue (32 words per queue) causes the whole packet to be discarded. A packet that exactly fills the remaining space is admitted.
- R4: A packet whose target queue has its `q_en` bit low is discarded whole.
- R5: `q_pkts` field i (6 bits at [6i+5:6i]) rises by one when the last word of a packet is written into queue i and falls by one when the last word of a packet is read from it. If both happen in the same cycle, the count is unchanged.
- R6: `out_vld` is high only while the queue selected by `deq_q` holds a complete packet, and `out_data`, `out_sop` and `out_eop` then show its oldest word. A `deq_pop` while `out_vld` is low has no effect.
- R7: Records have the layout {kind[1:0], queue[2:0], length[7:0], timestamp[15:0]}. The kind is 1 when a packet is admitted (written at its last word), 3 when a packet is discarded (written at its first word) and 2 when a packet is dequeued (written when its first word is popped). The length is taken from the header.
- R8: A record is written only while `cap_en` is high and the `mon_mask` bit of its queue is set. The packet path behaves the same either way.
- R9: The timestamp is a 16-bit counter that starts at 0 after reset and advances by one every cycle. Records from the same cycle carry equal timestamps.
- R10: The record FIFO holds 8 records. When a write-side and a read-side record occur in the same cycle, the write-side record is stored first. A record that finds no room is lost and sets `ev_ovf`, which stays set until reset. Packets are not affected.
- R11: After reset, every queue count is 0, and `out_vld`, `ev_vld` and `ev_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input word valid |
| in_sop | input | 1 | Input word is the header (first word) |
| in_eop | input | 1 | Input word is the last word |
| in_data | input | 16 | Input word: header has queue at [2:0] and length at [15:8] |
| q_en | input | 8 | Per-queue admission enable |
| q_limit | input | 40 | Per-queue packet limit, 5 bits per queue |
| cap_en | input | 1 | Global record capture enable |
| mon_mask | input | 8 | Per-queue record monitor select |
| deq_q | input | 3 | Queue selected for reading |
| deq_pop | input | 1 | Pop the shown word |
| out_vld | output | 1 | Selected queue holds a complete packet |
| out_data | output | 16 | Oldest word of the selected queue |
| out_sop | output | 1 | Shown word is a header |
| out_eop | output | 1 | Shown word is a last word |
| q_pkts | output | 48 | Complete packets stored per queue, 6 bits per queue |
| ev_vld | output | 1 | Record FIFO not empty |
| ev_rec | output | 29 | Oldest record |
| ev_pop | input | 1 | Remove the oldest record |
| ev_ovf | output | 1 | Sticky record-loss flag |

## Verification
The write side and the read side can both finish a packet on the same queue in the same cycle. The bench brings this about by popping the last word of the only stored single-word packet in the cycle that a new single-word packet arrives for that queue. The count must stay at one, and two records must appear in write-then-read order with equal timestamps. The bench also sweeps every queue past its limit, meets the word-space limit at an exact fit, and overfills the record FIFO while packets keep flowing.

// File: rtl/oq_pkg.sv
package oq_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ENQ  = 2'd1,
    EV_DEQ  = 2'd2,
    EV_DROP = 2'd3
  } oq_ev_e;
endpackage

// File: rtl/oq_queue.sv
module oq_queue #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         wr_sop,
  input  logic                         wr_eop,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic                         rd_sop,
  output logic                         rd_eop,
  output logic [$clog2(DEPTH+1)-1:0]   pkt_cnt,
  output logic [$clog2(DEPTH+1)-1:0]   free_words
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [DW+1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] wc_q, wc_d, pc_q, pc_d;

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    wc_d = wc_q;
    pc_d = pc_q;
    if (wr_en) wp_d = wp_q + AW'(1);
    if (rd_en) rp_d = rp_q + AW'(1);
    case ({wr_en, rd_en})
      2'b10:   wc_d = wc_q + CW'(1);
      2'b01:   wc_d = wc_q - CW'(1);
      default: wc_d = wc_q;
    endcase
    case ({wr_en && wr_eop, rd_en && rd_eop})
      2'b10:   pc_d = pc_q + CW'(1);
      2'b01:   pc_d = pc_q - CW'(1);
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
      wc_q <= '0;
      pc_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
      wc_q <= wc_d;
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wp_q] <= {wr_sop, wr_eop, wr_data};
  end

  assign {rd_sop, rd_eop, rd_data} = mem_q[rp_q];
  assign pkt_cnt    = pc_q;
  assign free_words = CW'(DEPTH) - wc_q;

  assert_no_word_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wc_q < CW'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (wc_q != '0));
  assert_pkts_le_words_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= wc_q);
endmodule

// File: rtl/oq_event_fifo.sv
module oq_event_fifo #(
  parameter int EW    = 29,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [EW-1:0] din_a,
  input  logic          push_b,
  input  logic [EW-1:0] din_b,
  input  logic          pop,
  output logic          vld,
  output logic [EW-1:0] dout,
  output logic          ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [EW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d, n_req, room, n_wr;
  logic          ovf_q, ovf_d, do_pop;
  logic [EW-1:0] w0;

  always_comb begin
    n_req  = CW'(push_a) + CW'(push_b);
    room   = CW'(DEPTH) - cnt_q;
    n_wr   = (n_req > room) ? room : n_req;
    w0     = push_a ? din_a : din_b;
    do_pop = pop && (cnt_q != '0);
    wp_d   = wp_q + n_wr[AW-1:0];
    rp_d   = do_pop ? rp_q + AW'(1) : rp_q;
    cnt_d  = cnt_q + n_wr - CW'(do_pop);
    ovf_d  = ovf_q || (n_req > room);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (n_wr != '0)     mem_q[wp_q]          <= w0;
    if (n_wr == CW'(2)) mem_q[wp_q + AW'(1)] <= din_b;
  end

  assign vld  = (cnt_q != '0);
  assign dout = mem_q[rp_q];
  assign ovf  = ovf_q;

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  assert_fill_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/outq_evcap.sv
module outq_evcap #(
  parameter int NQ      = 8,
  parameter int DW      = 16,
  parameter int QDEPTH  = 32,
  parameter int LIMW    = 5,
  parameter int TSW     = 16,
  parameter int EVDEPTH = 8,
  parameter int QF_LSB  = 0,
  parameter int LEN_LSB = 8,
  parameter int LENW    = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   in_vld,
  input  logic                                   in_sop,
  input  logic                                   in_eop,
  input  logic [DW-1:0]                          in_data,
  input  logic [NQ-1:0]                          q_en,
  input  logic [NQ*LIMW-1:0]                     q_limit,
  input  logic                                   cap_en,
  input  logic [NQ-1:0]                          mon_mask,
  input  logic [$clog2(NQ)-1:0]                  deq_q,
  input  logic                                   deq_pop,
  output logic                                   out_vld,
  output logic [DW-1:0]                          out_data,
  output logic                                   out_sop,
  output logic                                   out_eop,
  output logic [NQ*$clog2(QDEPTH+1)-1:0]         q_pkts,
  output logic                                   ev_vld,
  output logic [2+$clog2(NQ)+LENW+TSW-1:0]       ev_rec,
  input  logic                                   ev_pop,
  output logic                                   ev_ovf
);
  import oq_pkg::*;

  localparam int QIW  = $clog2(NQ);
  localparam int CW   = $clog2(QDEPTH+1);
  localparam int EW   = 2 + QIW + LENW + TSW;
  localparam int CMPW = 16;

  logic [CW-1:0]   pc_w [NQ];
  logic [CW-1:0]   fr_w [NQ];
  logic [DW-1:0]   hd_w [NQ];
  logic [LIMW-1:0] lim_w [NQ];
  logic [NQ-1:0]   hs_w, he_w, wr_en_v, rd_en_v;

  logic [QIW-1:0]  cur_q_q, cur_q_d, hdr_q, wr_q;
  logic [LENW-1:0] cur_len_q, cur_len_d, hdr_len, ev_len;
  logic            cur_keep_q, cur_keep_d;
  logic [TSW-1:0]  ts_q;
  logic            admit, wr_go, rd_have, pop_go, push_a, push_b;
  oq_ev_e          wev_kind;
  logic [EW-1:0]   rec_a, rec_b;

  always_comb begin
    hdr_q   = in_data[QF_LSB +: QIW];
    hdr_len = in_data[LEN_LSB +: LENW];
    admit   = q_en[hdr_q]
              && (CMPW'(pc_w[hdr_q]) < CMPW'(lim_w[hdr_q]))
              && (CMPW'(fr_w[hdr_q]) >= CMPW'(hdr_len));
    wr_q    = in_sop ? hdr_q : cur_q_q;
    wr_go   = in_vld && (in_sop ? admit : cur_keep_q);
    ev_len  = in_sop ? hdr_len : cur_len_q;

    cur_q_d    = cur_q_q;
    cur_len_d  = cur_len_q;
    cur_keep_d = cur_keep_q;
    if (in_vld && in_sop) begin
      cur_q_d    = hdr_q;
      cur_len_d  = hdr_len;
      cur_keep_d = admit && !in_eop;
    end else if (in_vld && in_eop) begin
      cur_keep_d = 1'b0;
    end

    wev_kind = EV_NONE;
    if (in_vld && in_sop && !admit) wev_kind = EV_DROP;
    else if (wr_go && in_eop)       wev_kind = EV_ENQ;

    rd_have = (pc_w[deq_q] != '0);
    pop_go  = deq_pop && rd_have;

    push_a = (wev_kind != EV_NONE) && cap_en && mon_mask[wr_q];
    push_b = pop_go && hs_w[deq_q] && cap_en && mon_mask[deq_q];
    rec_a  = {wev_kind, wr_q, ev_len, ts_q};
    rec_b  = {EV_DEQ, deq_q, hd_w[deq_q][LEN_LSB +: LENW], ts_q};

    for (int i = 0; i < NQ; i++) begin
      wr_en_v[i] = wr_go  && (wr_q  == QIW'(i));
      rd_en_v[i] = pop_go && (deq_q == QIW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q_q    <= '0;
      cur_len_q  <= '0;
      cur_keep_q <= 1'b0;
      ts_q       <= '0;
    end else begin
      cur_q_q    <= cur_q_d;
      cur_len_q  <= cur_len_d;
      cur_keep_q <= cur_keep_d;
      ts_q       <= ts_q + TSW'(1);
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    assign lim_w[g] = q_limit[g*LIMW +: LIMW];
    assign q_pkts[g*CW +: CW] = pc_w[g];
    oq_queue #(.DW(DW), .DEPTH(QDEPTH)) i_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en_v[g]),
      .wr_data    (in_data),
      .wr_sop     (in_sop),
      .wr_eop     (in_eop),
      .rd_en      (rd_en_v[g]),
      .rd_data    (hd_w[g]),
      .rd_sop     (hs_w[g]),
      .rd_eop     (he_w[g]),
      .pkt_cnt    (pc_w[g]),
      .free_words (fr_w[g])
    );
  end

  assign out_vld  = rd_have;
  assign out_data = hd_w[deq_q];
  assign out_sop  = hs_w[deq_q];
  assign out_eop  = he_w[deq_q];

  oq_event_fifo #(.EW(EW), .DEPTH(EVDEPTH)) i_evf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_a (push_a),
    .din_a  (rec_a),
    .push_b (push_b),
    .din_b  (rec_b),
    .pop    (ev_pop),
    .vld    (ev_vld),
    .dout   (ev_rec),
    .ovf    (ev_ovf)
  );
endmodule

// File: tb/test_outq_evcap.sv
module test_outq_evcap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [15:0] in_data = '0;
  logic [7:0]  q_en = 8'hFF;
  logic [39:0] q_limit = '0;
  logic        cap_en = 1'b1;
  logic [7:0]  mon_mask = 8'hFF;
  logic [2:0]  deq_q = '0;
  logic        deq_pop = 1'b0;
  logic        out_vld, out_sop, out_eop;
  logic [15:0] out_data;
  logic [47:0] q_pkts;
  logic        ev_vld, ev_ovf;
  logic [28:0] ev_rec;
  logic        ev_pop = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int mtag [8][32];
  int mlen [8][32];
  int mh [8];
  int mc [8];

  always #10 clk = ~clk;

  outq_evcap i_outq_evcap (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .q_en(q_en), .q_limit(q_limit), .cap_en(cap_en),
    .mon_mask(mon_mask), .deq_q(deq_q), .deq_pop(deq_pop), .out_vld(out_vld),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .q_pkts(q_pkts),
    .ev_vld(ev_vld), .ev_rec(ev_rec), .ev_pop(ev_pop), .ev_ovf(ev_ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cnt(input int q);
    return int'(q_pkts[q*6 +: 6]);
  endfunction

  function automatic logic [15:0] word(input int q, input int len, input int tag, input int k);
    if (k == 0) return {len[7:0], tag[4:0], q[2:0]};
    return {q[2:0], tag[4:0], k[7:0]};
  endfunction

  task automatic model_push(input int q, input int len, input int tag);
    mtag[q][(mh[q] + mc[q]) % 32] = tag;
    mlen[q][(mh[q] + mc[q]) % 32] = len;
    mc[q]++;
  endtask

  task automatic send(input int q, input int len, input int tag);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_vld = 1'b1; in_sop = (k == 0); in_eop = (k == len - 1);
      in_data = word(q, len, tag, k);
    end
    @(negedge clk);
    in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic expect_ev(input int kind, input int q, input int len, input string req, output int ts);
    int act, exp;
    chk(ev_vld === 1'b1, req, int'(ev_vld), 1);
    act = int'(ev_rec[28:16]);
    exp = (kind << 11) | (q << 8) | len;
    chk(act == exp, req, act, exp);
    ts = int'(ev_rec[15:0]);
    ev_pop = 1'b1;
    @(negedge clk);
    ev_pop = 1'b0;
  endtask

  task automatic deq_pkt(input int q, input int len, input int tag, input string req);
    deq_q = 3'(q);
    for (int k = 0; k < len; k++) begin
      #1;
      chk(out_vld === 1'b1, req, int'(out_vld), 1);
      chk(out_data === word(q, len, tag, k), req, int'(out_data), int'(word(q, len, tag, k)));
      chk({out_sop, out_eop} === {k == 0, k == len - 1}, req, int'({out_sop, out_eop}),
          int'({k == 0, k == len - 1}));
      deq_pop = 1'b1;
      @(negedge clk);
    end
    deq_pop = 1'b0;
  endtask

  task automatic deq_all(input int q, input bit ev_on);
    int ts;
    while (mc[q] > 0) begin
      deq_pkt(q, mlen[q][mh[q]], mtag[q][mh[q]], "R1 order");
      if (ev_on) expect_ev(2, q, mlen[q][mh[q]], "R7 deq record", ts);
      else chk(ev_vld === 1'b0, "R8 no deq record", int'(ev_vld), 0);
      mh[q] = (mh[q] + 1) % 32;
      mc[q]--;
      chk(cnt(q) == mc[q], "R5 count after read", cnt(q), mc[q]);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int ts, t1, t2;
    bit acc;
    for (int q = 0; q < 8; q++) begin
      mh[q] = 0; mc[q] = 0;
      q_limit[q*5 +: 5] = 5'(q + 1);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(q_pkts == '0, "R11 counts", int'(q_pkts[31:0]), 0);
    chk({out_vld, ev_vld, ev_ovf} == 3'b000, "R11 flags", int'({out_vld, ev_vld, ev_ovf}), 0);

    // R2 R7: sweep every queue past its packet limit
    for (int q = 0; q < 8; q++) begin
      for (int n = 0; n < q + 3; n++) begin
        acc = (mc[q] < q + 1);
        send(q, 1 + n % 3, n);
        if (acc) model_push(q, 1 + n % 3, n);
        expect_ev(acc ? 1 : 3, q, 1 + n % 3, acc ? "R7 enq record" : "R2 drop record", ts);
        chk(cnt(q) == mc[q], "R2 count at limit", cnt(q), mc[q]);
      end
    end
    // R1 R6: drain all queues in order
    for (int q = 7; q >= 0; q--) deq_all(q, 1'b1);

    // R6: pop on an empty queue is ignored
    deq_q = 3'd3; #1;
    chk(out_vld === 1'b0, "R6 empty not valid", int'(out_vld), 0);
    deq_pop = 1'b1; @(negedge clk); deq_pop = 1'b0;
    send(3, 2, 7); model_push(3, 2, 7);
    expect_ev(1, 3, 2, "R7 enq record", ts);
    deq_all(3, 1'b1);

    // R3: word space
    q_limit[2*5 +: 5] = 5'd31;
    for (int n = 0; n < 3; n++) begin
      send(2, 10, n); model_push(2, 10, n);
      expect_ev(1, 2, 10, "R3 fits", ts);
    end
    send(2, 10, 3);
    expect_ev(3, 2, 10, "R3 no room drop", ts);
    send(2, 2, 4); model_push(2, 2, 4);
    expect_ev(1, 2, 2, "R3 exact fit", ts);
    chk(cnt(2) == 4, "R3 count", cnt(2), 4);
    deq_all(2, 1'b1);

    // R4: queue switched off
    q_en[5] = 1'b0;
    send(5, 1, 1);
    expect_ev(3, 5, 1, "R4 disabled drop", ts);
    chk(cnt(5) == 0, "R4 count", cnt(5), 0);
    q_en[5] = 1'b1;

    // R8: monitor mask and global enable
    mon_mask[3] = 1'b0;
    send(3, 2, 9); model_push(3, 2, 9);
    chk(ev_vld === 1'b0, "R8 masked queue", int'(ev_vld), 0);
    chk(cnt(3) == 1, "R8 packet kept", cnt(3), 1);
    deq_all(3, 1'b0);
    mon_mask[3] = 1'b1;
    cap_en = 1'b0;
    send(4, 1, 2); model_push(4, 1, 2);
    chk(ev_vld === 1'b0, "R8 capture off", int'(ev_vld), 0);
    deq_all(4, 1'b0);
    cap_en = 1'b1;

    // R5 R9 R10: same-cycle finish of write and read on queue 0
    q_limit[4:0] = 5'd4;
    send(0, 1, 20); model_push(0, 1, 20);
    expect_ev(1, 0, 1, "R7 enq record", ts);
    @(negedge clk);
    deq_q = 3'd0; #1;
    chk(out_data === word(0, 1, 20, 0), "R6 head shown", int'(out_data), int'(word(0, 1, 20, 0)));
    in_vld = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = word(0, 1, 21, 0);
    deq_pop = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; deq_pop = 1'b0;
    mh[0] = (mh[0] + 1) % 32; mc[0]--; model_push(0, 1, 21);
    chk(cnt(0) == 1, "R5 simultaneous hold", cnt(0), 1);
    expect_ev(1, 0, 1, "R10 write record first", t1);
    expect_ev(2, 0, 1, "R10 read record second", t2);
    chk(t1 == t2, "R9 same-cycle stamp", t2, t1);
    deq_all(0, 1'b1);

    // R9: stamp spacing
    send(1, 1, 1); send(1, 1, 2);
    model_push(1, 1, 1); model_push(1, 1, 2);
    expect_ev(1, 1, 1, "R9 first", t1);
    expect_ev(1, 1, 1, "R9 second", t2);
    chk(t2 - t1 == 2, "R9 stamp step", t2 - t1, 2);
    deq_all(1, 1'b1);

    // R10: record FIFO overflow while packets flow
    q_limit[6*5 +: 5] = 5'd16;
    for (int n = 0; n < 9; n++) begin
      send(6, 1, n); model_push(6, 1, n);
      chk(ev_ovf === (n == 8), "R10 overflow flag", int'(ev_ovf), int'(n == 8));
    end
    chk(cnt(6) == 9, "R10 packets unaffected", cnt(6), 9);
    for (int n = 0; n < 8; n++) expect_ev(1, 6, 1, "R10 kept records", ts);
    chk(ev_vld === 1'b0, "R10 ninth record lost", int'(ev_vld), 0);
    chk(ev_ovf === 1'b1, "R10 flag sticky", int'(ev_ovf), 1);
    deq_all(6, 1'b1);

    finish_run();
  end
endmodule